// File: doc/BRIEF.md
# Bidirectional LCD Common Scan Register

This block drives the row side of a dot-matrix LCD with 160 row outputs. A scan bit moves through a 160-stage shift register on each rising edge of the shift clock. One direction input sets which way it moves. A mode input can split the chain into two halves of 80 stages. In that dual mode a second scan input feeds the upper half, so two scan bits travel at once.

Every stage turns into a 2-bit drive code. The code picks one of four analog levels from the stage bit and the frame-inversion input. An active-low display-off input acts at once, without waiting for the clock. While it is low, every code is forced to the lowest (VSS) level, a flag goes high, and the register is cleared. Normal shifting resumes once the input returns high.

Top module: `lcd_common_scan`

## Requirements
- R1: A synchronous active-high reset clears every stage. After a reset edge, every stage bit (the upper bit of each 2-bit code) reads 0.
- R2: In single mode with `shift_dir` = 1, each clock moves stage i into stage i+1. `scan_a` enters stage 1 (code bits [1:0]).
- R3: In single mode with `shift_dir` = 0, each clock moves stage i+1 into stage i. `scan_a` enters stage 160 (code bits [319:318]).
- R4: In dual mode (`dual_mode` = 1) with `shift_dir` = 1, `scan_b` enters stage 81. The bit leaving stage 80 is dropped and does not reach stage 81.
- R5: In dual mode with `shift_dir` = 0, `scan_a` enters stage 80 and `scan_b` enters stage 160. The bit leaving stage 81 is dropped and does not reach stage 80.
- R6: While `disp_off_n` is low, without waiting for a clock edge, every code is 00 and `blank_o` is 1. The register is cleared, so every stage reads deselected after `disp_off_n` returns high.
- R7: Stage i drives the code {stage bit, `frame_inv`} on bits [2i-1:2i-2]. The four codes are:
  - 00: deselected, frame low
  - 01: deselected, frame high
  - 10: selected, frame low
  - 11: selected, frame high
- R8: In single mode the chain crosses between stages 80 and 81 unbroken, and `scan_b` has no effect.
- R9: A bit shifted past the last stage in the shift direction is lost. The chain does not wrap around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| shift_dir | input | 1 | 1: toward stage 160, 0: toward stage 1 |
| dual_mode | input | 1 | 1: two 80-stage halves, 0: one chain |
| scan_a | input | 1 | Scan data, main entry |
| scan_b | input | 1 | Scan data for the upper half in dual mode |
| frame_inv | input | 1 | Frame inversion signal |
| disp_off_n | input | 1 | Display off, active low, asynchronous |
| lvl_code | output | 320 | Two code bits per stage, stage 1 in the low bits |
| blank_o | output | 1 | High while outputs are forced to VSS |

## Verification
The clocked shift properties assume that `disp_off_n` does not pulse low and back high between two clock edges without being seen at an edge. A consequent that finds `disp_off_n` low at the later edge is treated as satisfied. The stimulus changes every input only at the falling clock edge, and it lowers `disp_off_n` for at least one full cycle. The mode and direction are changed only while the affected stages are known, so the model in the bench stays in step with the design.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        LVL_DESEL_LO = 2'b00,
        LVL_DESEL_HI = 2'b01,
        LVL_SEL_LO   = 2'b10,
        LVL_SEL_HI   = 2'b11
    } lvl_code_e;

    typedef struct packed {
        logic dir_up;
        logic dual;
        logic din_lo;
        logic din_hi;
    } shift_ctrl_t;

    function automatic lvl_code_e drive_code(input logic sel, input logic fr);
        lvl_code_e c;
        case ({sel, fr})
            2'b00:   c = LVL_DESEL_LO;
            2'b01:   c = LVL_DESEL_HI;
            2'b10:   c = LVL_SEL_LO;
            default: c = LVL_SEL_HI;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lcd_scan_chain.sv
module lcd_scan_chain
    import lcd_scan_pkg::*;
#(
    parameter int N = 160
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr_n,
    input  shift_ctrl_t ctrl,
    output logic [N-1:0] q
);
    localparam int HALF = N / 2;

    logic [N-1:0] nxt;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (ctrl.dir_up) begin
                if (i == 0)
                    nxt[i] = ctrl.din_lo;
                else if (ctrl.dual && i == HALF)
                    nxt[i] = ctrl.din_hi;
                else
                    nxt[i] = q[i-1];
            end else begin
                if (i == N-1)
                    nxt[i] = ctrl.dual ? ctrl.din_hi : ctrl.din_lo;
                else if (ctrl.dual && i == HALF-1)
                    nxt[i] = ctrl.din_lo;
                else
                    nxt[i] = q[i+1];
            end
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= '0;
        else if (rst)
            q <= '0;
        else
            q <= nxt;
    end
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
    import lcd_scan_pkg::*;
#(
    parameter int N = 160
) (
    input  logic [N-1:0]   sel,
    input  logic           frame,
    input  logic           force_vss,
    output logic [2*N-1:0] code
);
    for (genvar g = 0; g < N; g++) begin : g_stage
        lvl_code_e c;
        assign c = force_vss ? LVL_DESEL_LO : drive_code(sel[g], frame);
        assign code[2*g +: 2] = c;
    end
endmodule

// File: rtl/lcd_common_scan.sv
module lcd_common_scan
    import lcd_scan_pkg::*;
#(
    parameter int N = 160
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_dir,
    input  logic           dual_mode,
    input  logic           scan_a,
    input  logic           scan_b,
    input  logic           frame_inv,
    input  logic           disp_off_n,
    output logic [2*N-1:0] lvl_code,
    output logic           blank_o
);
    shift_ctrl_t  ctrl;
    logic [N-1:0] stage_q;

    assign ctrl = '{dir_up: shift_dir, dual: dual_mode, din_lo: scan_a, din_hi: scan_b};
    assign blank_o = ~disp_off_n;

    lcd_scan_chain #(.N(N)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .clr_n (disp_off_n),
        .ctrl  (ctrl),
        .q     (stage_q)
    );

    lcd_level_enc #(.N(N)) u_enc (
        .sel       (stage_q),
        .frame     (frame_inv),
        .force_vss (blank_o),
        .code      (lvl_code)
    );
endmodule

// File: rtl/lcd_common_scan_chk.sv
module lcd_common_scan_chk #(
    parameter int N = 160
) (
    input logic           clk,
    input logic           rst,
    input logic           shift_dir,
    input logic           dual_mode,
    input logic           scan_a,
    input logic           scan_b,
    input logic           frame_inv,
    input logic           disp_off_n,
    input logic [2*N-1:0] lvl_code,
    input logic           blank_o
);
    localparam int HALF = N / 2;

    logic [N-1:0] sel_v;
    logic [N-1:0] fr_v;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            sel_v[i] = lvl_code[2*i+1];
            fr_v[i]  = lvl_code[2*i];
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        (rst && disp_off_n) |=> (!disp_off_n || sel_v == '0));

    // R2
    up_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_dir && !dual_mode && disp_off_n) |=>
        (!disp_off_n || (sel_v[0] == $past(scan_a) && sel_v[N-1:1] == $past(sel_v[N-2:0]))));

    // R3
    down_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_dir && !dual_mode && disp_off_n) |=>
        (!disp_off_n || (sel_v[N-1] == $past(scan_a) && sel_v[N-2:0] == $past(sel_v[N-1:1]))));

    // R4
    dual_up_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_dir && dual_mode && disp_off_n) |=>
        (!disp_off_n || (sel_v[HALF] == $past(scan_b) && sel_v[0] == $past(scan_a))));

    // R5
    dual_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_dir && dual_mode && disp_off_n) |=>
        (!disp_off_n || (sel_v[HALF-1] == $past(scan_a) && sel_v[N-1] == $past(scan_b))));

    // R6
    blank_force_chk: assert property (@(posedge clk)
        !disp_off_n |-> (blank_o && lvl_code == '0));

    // R7
    frame_code_chk: assert property (@(posedge clk)
        disp_off_n |-> (!blank_o && fr_v == {N{frame_inv}}));
endmodule

bind lcd_common_scan lcd_common_scan_chk #(.N(N)) u_chk (.*);

// File: tb/sim_lcd_common_scan.sv
module sim_lcd_common_scan;
    localparam int N = 160;
    localparam int HALF = N / 2;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           shift_dir = 1'b1;
    logic           dual_mode = 1'b0;
    logic           scan_a = 1'b0;
    logic           scan_b = 1'b0;
    logic           frame_inv = 1'b0;
    logic           disp_off_n = 1'b1;
    logic [2*N-1:0] lvl_code;
    logic           blank_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [N-1:0]   model = '0;
    logic [2*N-1:0] exp_q[$];
    logic           exp_blank_q[$];
    string          tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_common_scan #(.N(N)) u0 (
        .clk(clk), .rst(rst), .shift_dir(shift_dir), .dual_mode(dual_mode),
        .scan_a(scan_a), .scan_b(scan_b), .frame_inv(frame_inv),
        .disp_off_n(disp_off_n), .lvl_code(lvl_code), .blank_o(blank_o)
    );

    function automatic logic [2*N-1:0] expect_codes(logic [N-1:0] m, logic fr, logic blk);
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++)
            v[2*i +: 2] = blk ? 2'b00 : {m[i], fr};
        return v;
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic step(input logic r, input logic dir, input logic dual,
                        input logic a, input logic b, input logic fr,
                        input logic don, input string tag);
        logic [N-1:0] nm;
        @(negedge clk);
        rst = r; shift_dir = dir; dual_mode = dual;
        scan_a = a; scan_b = b; frame_inv = fr; disp_off_n = don;
        if (!don || r) begin
            nm = '0;
        end else if (dir) begin
            for (int i = 0; i < N; i++)
                nm[i] = (i == 0) ? a : ((dual && i == HALF) ? b : model[i-1]);
        end else begin
            for (int i = 0; i < N; i++)
                nm[i] = (i == N-1) ? (dual ? b : a) : ((dual && i == HALF-1) ? a : model[i+1]);
        end
        model = nm;
        exp_q.push_back(expect_codes(nm, fr, !don));
        exp_blank_q.push_back(!don);
        tag_q.push_back(tag);
    endtask

    // Monitor: pops and compares after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                logic [2*N-1:0] e;
                logic eb;
                string t;
                e = exp_q.pop_front();
                eb = exp_blank_q.pop_front();
                t = tag_q.pop_front();
                n_vec++;
                if (lvl_code !== e || blank_o !== eb) begin
                    n_bad++;
                    $display("FAIL %s: codes=%h blank=%b expected codes=%h blank=%b",
                             t, lvl_code, blank_o, e, eb);
                end
            end
        end
    end

    task automatic drop_display();
        @(negedge clk);
        disp_off_n = 1'b0;
        #1;
        n_vec++;
        if (lvl_code !== '0 || blank_o !== 1'b1) begin
            n_bad++;
            $display("FAIL R6: codes=%h blank=%b expected codes=0 blank=1", lvl_code, blank_o);
        end
        model = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset
        step(1, 1, 0, 1, 0, 0, 1, "R1");
        step(1, 1, 0, 1, 1, 1, 1, "R1");
        // R2 / R8: single mode upward, scan_b held high must be ignored, frame toggles (R7)
        step(0, 1, 0, 1, 1, 0, 1, "R2");
        for (int k = 0; k < 84; k++)
            step(0, 1, 0, (k % 7 == 3), 1, k[0], 1, "R8");
        // R9: shift past stage 160 so everything falls off the end
        for (int k = 0; k < N; k++)
            step(0, 1, 0, 0, 1, k[1], 1, "R9");
        // R3: single mode downward
        step(0, 0, 0, 1, 0, 1, 1, "R3");
        for (int k = 0; k < 90; k++)
            step(0, 0, 0, (k % 11 == 2), 1, 0, 1, "R3");
        // R6: display off mid-run, held over an edge, then released
        drop_display();
        step(0, 0, 0, 1, 1, 1, 0, "R6");
        step(0, 0, 0, 0, 0, 1, 1, "R6");
        step(0, 0, 0, 0, 0, 0, 1, "R6");
        // R4: dual mode upward; stage 80 content must not cross into 81
        for (int k = 0; k < 85; k++)
            step(0, 1, 1, (k == 0 || k == 5), (k == 2), k[0], 1, "R4");
        step(0, 1, 1, 0, 0, 1, 1, "R4");
        // R5: dual mode downward; stage 81 content must not cross into 80
        for (int k = 0; k < 90; k++)
            step(0, 0, 1, (k == 1), (k == 0 || k == 4), 0, 1, "R5");
        // R7: all four codes present with frame high, then low
        step(0, 1, 0, 1, 0, 1, 1, "R7");
        step(0, 1, 0, 0, 0, 0, 1, "R7");
        // R1 reset from a loaded chain
        step(1, 1, 0, 0, 0, 1, 1, "R1");
        step(0, 1, 0, 0, 0, 1, 1, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule